// File: doc/BRIEF.md
# Microcontroller Buffer Window Address Mapper

This block sits between an 8-bit microcontroller's 64 kbyte address space and a byte-wide DRAM frame buffer. Each CPU address is sorted into one of four regions. The low half of the space is a paged linear view of the buffer. Three 4 kbyte windows show three consecutive 3 kbyte frames. One region holds the on-chip control registers. The last region is unused, and the data bus stays undriven when it is read. The buffer byte address is produced combinationally from the CPU address and from pointer registers held inside the block.

The frame windows follow a programmable frame number. The second and third windows show the next two logical frames. When those frames would pass an inclusive last-frame pointer, they continue from a start-frame pointer instead. The frame number is written as two bytes. Writing the low byte only stages it. Writing the high byte commits both bytes. If the buffer access logic reports that an access is in flight, the commit is held back until that access ends. All pointers reset to zero.

Top module: `buf_window_map`

## Requirements
- R1: For CPU addresses 0x0000 to 0x7FFF, `region` is 0 and `buf_addr` equals page × 32768 + cpu_addr[14:0].
- R2: For CPU addresses 0x8000 to 0x8FFF, `region` is 1 and `buf_addr` equals frame × 3072 + cpu_addr[11:0].
- R3: Addresses 0x9000 to 0x9FFF use frame + 1, and addresses 0xA000 to 0xAFFF use frame + 2, with the same 3072 stride and 12-bit offset; `region` is 1.
- R4: When frame + k (k = 1 or 2) is greater than the last-frame pointer, the window uses start + (frame + k − last − 1), taken modulo 2^FW.
- R5: Addresses 0xB000 to 0xEFFF give `region` 3 and `buf_addr` 0. `bus_float` is 1 exactly when such an address is read (cpu_rd=1, cpu_wr=0), and 0 for every other address or strobe combination.
- R6: Addresses 0xF000 to 0xFFFF give `region` 2 and `buf_addr` 0.
- R7: Register writes use `reg_sel` codes: 0 page, 1 frame low byte, 2 frame high byte, 3 last low, 4 last high, 5 start low, 6 start high. A write of code 1 alone leaves the frame windows unchanged. A write of code 2 commits {high, staged low} at that clock edge.
- R8: If `acc_busy` is 1 at the edge of a high-byte write, the frame number keeps its old value in every cycle in which `acc_busy` stays 1. It takes the new value at the first edge where `acc_busy` is 0.
- R9: After reset, all pointers (page, frame, last, start) are zero.
- R10: Results wider than AW bits are truncated modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| reg_wr | input | 1 | Pointer register write enable |
| reg_sel | input | 3 | Pointer register select |
| reg_wdata | input | 8 | Pointer register write byte |
| acc_busy | input | 1 | A buffer access using the frame counter is in flight |
| buf_addr | output | AW | Buffer byte address |
| region | output | 2 | Region code: 0 linear, 1 frame, 2 control, 3 unused |
| bus_float | output | 1 | Data bus must be left undriven |

## Verification
The bench builds the block with its defaults: AW=22, FW=16 and PW=8. With these values a page of 255 or a frame near 2047 overflows the 4 Mbyte address, so the modulo truncation of R10 is reached. The 16-bit pointers also let random last and start values force the wrap of R4 from either window. Directed cases cover a frame equal to last and to last − 1, high-byte writes held off by a multi-cycle busy, and a low-byte write with no high-byte write after it.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef enum logic [1:0] {
    RGN_LINEAR = 2'd0,
    RGN_FRAME  = 2'd1,
    RGN_CTRL   = 2'd2,
    RGN_NONE   = 2'd3
  } rgn_e;

  localparam logic [2:0] SEL_PAGE   = 3'd0;
  localparam logic [2:0] SEL_FRM_LO = 3'd1;
  localparam logic [2:0] SEL_FRM_HI = 3'd2;
  localparam logic [2:0] SEL_LST_LO = 3'd3;
  localparam logic [2:0] SEL_LST_HI = 3'd4;
  localparam logic [2:0] SEL_STA_LO = 3'd5;
  localparam logic [2:0] SEL_STA_HI = 3'd6;
endpackage

// File: rtl/bwm_ptr_regs.sv
module bwm_ptr_regs #(
  parameter int FW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          acc_busy,
  output logic [FW-1:0] frame_q,
  output logic [FW-1:0] last_q,
  output logic [FW-1:0] start_q,
  output logic [PW-1:0] page_q
);
  import bwm_pkg::*;
  localparam int HW = FW - 8;

  logic [7:0]    lo_q, lo_d;
  logic [FW-1:0] pend_val_q, pend_val_d, frame_d, last_d, start_d;
  logic          pend_q, pend_d;
  logic [PW-1:0] page_d;
  logic          hi_wr;

  assign hi_wr = reg_wr && (reg_sel == SEL_FRM_HI);

  always_comb begin
    lo_d       = lo_q;
    pend_d     = pend_q;
    pend_val_d = pend_val_q;
    frame_d    = frame_q;
    last_d     = last_q;
    start_d    = start_q;
    page_d     = page_q;
    if (reg_wr) begin
      case (reg_sel)
        SEL_PAGE:   page_d = PW'(reg_wdata);
        SEL_FRM_LO: lo_d = reg_wdata;
        SEL_LST_LO: last_d = {last_q[FW-1:8], reg_wdata};
        SEL_LST_HI: last_d = {reg_wdata[HW-1:0], last_q[7:0]};
        SEL_STA_LO: start_d = {start_q[FW-1:8], reg_wdata};
        SEL_STA_HI: start_d = {reg_wdata[HW-1:0], start_q[7:0]};
        default: ;
      endcase
    end
    if (hi_wr) begin
      if (acc_busy) begin
        pend_d     = 1'b1;
        pend_val_d = {reg_wdata[HW-1:0], lo_q};
      end else begin
        pend_d  = 1'b0;
        frame_d = {reg_wdata[HW-1:0], lo_q};
      end
    end else if (pend_q && !acc_busy) begin
      pend_d  = 1'b0;
      frame_d = pend_val_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      frame_q    <= '0;
      last_q     <= '0;
      start_q    <= '0;
      page_q     <= '0;
    end else begin
      lo_q       <= lo_d;
      pend_q     <= pend_d;
      pend_val_q <= pend_val_d;
      frame_q    <= frame_d;
      last_q     <= last_d;
      start_q    <= start_d;
      page_q     <= page_d;
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_busy |=> $stable(frame_q)); // R8
  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !acc_busy && !hi_wr) |=> !pend_q); // R8
  AST_LOAD_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr && !pend_q) |=> $stable(frame_q)); // R7
endmodule

// File: rtl/bwm_frame_step.sv
module bwm_frame_step #(
  parameter int FW   = 16,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] frame,
  input  logic [FW-1:0] last,
  input  logic [FW-1:0] start,
  output logic [FW-1:0] res
);
  logic [FW:0] sum;
  logic        wrap;

  assign sum  = {1'b0, frame} + (FW+1)'(STEP);
  assign wrap = sum > {1'b0, last};

  always_comb begin
    if (wrap) res = FW'({1'b0, start} + sum - {1'b0, last} - (FW+1)'(1));
    else      res = sum[FW-1:0];
  end

  AST_WRAP_PAST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ({1'b0, start} + sum - {1'b0, last} - (FW+1)'(1)) < (FW+1)'(1 << FW))
      |-> res >= start); // R4
endmodule

// File: rtl/bwm_decode.sv
module bwm_decode #(
  parameter int AW = 22,
  parameter int FW = 16,
  parameter int PW = 8
) (
  input  logic [15:0]   cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [PW-1:0] page,
  input  logic [FW-1:0] win0,
  input  logic [FW-1:0] win1,
  input  logic [FW-1:0] win2,
  output logic [AW-1:0] buf_addr,
  output logic [1:0]    region,
  output logic          bus_float
);
  import bwm_pkg::*;
  localparam logic [AW-1:0] FRM_BYTES = AW'(3072);
  localparam logic [AW-1:0] PG_BYTES  = AW'(32768);

  logic [FW-1:0] sel_frm;
  logic [3:0]    nib;

  assign nib = cpu_addr[15:12];

  always_comb begin
    case (nib)
      4'h9:    sel_frm = win1;
      4'hA:    sel_frm = win2;
      default: sel_frm = win0;
    endcase
    buf_addr = '0;
    region   = RGN_NONE;
    if (!cpu_addr[15]) begin
      region   = RGN_LINEAR;
      buf_addr = AW'(page) * PG_BYTES + AW'(cpu_addr[14:0]);
    end else if (nib <= 4'hA) begin
      region   = RGN_FRAME;
      buf_addr = AW'(sel_frm) * FRM_BYTES + AW'(cpu_addr[11:0]);
    end else if (nib == 4'hF) begin
      region   = RGN_CTRL;
    end
  end

  assign bus_float = (region == RGN_NONE) && cpu_rd && !cpu_wr;
endmodule

// File: rtl/buf_window_map.sv
module buf_window_map #(
  parameter int AW = 22,
  parameter int FW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cpu_addr,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          acc_busy,
  output logic [AW-1:0] buf_addr,
  output logic [1:0]    region,
  output logic          bus_float
);
  localparam int NWIN = 3;

  logic [FW-1:0] frame_q, last_q, start_q;
  logic [PW-1:0] page_q;
  logic [FW-1:0] win [NWIN];

  bwm_ptr_regs #(.FW(FW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acc_busy(acc_busy), .frame_q(frame_q),
    .last_q(last_q), .start_q(start_q), .page_q(page_q));

  assign win[0] = frame_q;

  for (genvar k = 1; k < NWIN; k++) begin : g_step
    bwm_frame_step #(.FW(FW), .STEP(k)) u_step (
      .clk(clk), .rst_n(rst_n), .frame(frame_q), .last(last_q),
      .start(start_q), .res(win[k]));
  end

  bwm_decode #(.AW(AW), .FW(FW), .PW(PW)) u_dec (
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .page(page_q),
    .win0(win[0]), .win1(win[1]), .win2(win[2]),
    .buf_addr(buf_addr), .region(region), .bus_float(bus_float));

  AST_FLOAT_UNUSED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_float |-> (cpu_addr[15:12] >= 4'hB && cpu_addr[15:12] <= 4'hE)); // R5
  AST_CTRL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:12] == 4'hF) |-> (region == 2'd2 && buf_addr == '0)); // R6
  AST_LINEAR_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (region == 2'd0 && !bus_float)); // R1
endmodule

// File: tb/buf_window_map_tb.sv
module buf_window_map_tb;
  localparam int AW = 22;
  localparam int FW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, reg_wr = 1'b0, acc_busy = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [AW-1:0] buf_addr;
  logic [1:0] region;
  logic bus_float;

  int n_tests = 0, n_fail = 0;
  int m_page = 0, m_frame = 0, m_last = 0, m_start = 0;

  always #4 clk = ~clk;

  buf_window_map u_dut (.*);

  function automatic int win_frame(int k);
    int s = m_frame + k;
    if (k > 0 && s > m_last) s = m_start + (s - m_last - 1);
    return s % 65536;
  endfunction

  function automatic int exp_addr(int a);
    int n = a >> 12;
    longint r;
    if (a < 32768) r = longint'(m_page) * 32768 + (a % 32768);
    else if (n <= 10) r = longint'(win_frame(n - 8)) * 3072 + (a % 4096);
    else r = 0;
    return int'(r % (longint'(1) << AW));
  endfunction

  function automatic int exp_rgn(int a);
    int n = a >> 12;
    if (a < 32768) return 0;
    if (n <= 10) return 1;
    if (n == 15) return 2;
    return 3;
  endfunction

  task automatic check(string req, int a, bit rd, bit wr);
    int ea = exp_addr(a);
    int er = exp_rgn(a);
    bit ef = (er == 3) && rd && !wr;
    cpu_addr = 16'(a); cpu_rd = rd; cpu_wr = wr;
    #1;
    n_tests++;
    if (buf_addr !== AW'(ea) || region !== 2'(er) || bus_float !== ef) begin
      n_fail++;
      $display("FAIL %s addr=%h act=%h/%0d/%0b exp=%h/%0d/%0b", req, a,
               buf_addr, region, bus_float, ea, er, ef);
    end
  endtask

  task automatic wr_reg(int sel, int d);
    reg_wr = 1'b1; reg_sel = 3'(sel); reg_wdata = 8'(d);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_all(int pg, int fr, int la, int st);
    wr_reg(0, pg); m_page = pg;
    wr_reg(3, la & 255); wr_reg(4, la >> 8); m_last = la;
    wr_reg(5, st & 255); wr_reg(6, st >> 8); m_start = st;
    wr_reg(1, fr & 255); wr_reg(2, fr >> 8); m_frame = fr;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state: every pointer is zero
    check("R9", 16'h0123, 1, 0);
    check("R9", 16'h8456, 1, 0);
    check("R9", 16'h9001, 1, 0);
    // R5 / R6 fixed regions
    check("R5", 16'hB000, 1, 0);
    check("R5", 16'hEFFF, 1, 0);
    check("R5", 16'hC000, 0, 1);
    check("R5", 16'hD000, 0, 0);
    check("R6", 16'hF000, 1, 0);
    check("R6", 16'hFFFF, 0, 1);
    // R1 / R2 / R3 directed, no wrap
    set_all(3, 10, 100, 5);
    check("R1", 16'h7FFF, 1, 0);
    check("R2", 16'h8FFF, 1, 0);
    check("R3", 16'h9000, 1, 0);
    check("R3", 16'hA010, 1, 0);
    // R4 frame = last: both following windows wrap
    set_all(0, 100, 100, 5);
    check("R4", 16'h9002, 1, 0);
    check("R4", 16'hA002, 1, 0);
    // R4 frame = last-1: only the third window wraps
    set_all(0, 99, 100, 7);
    check("R4", 16'h9000, 1, 0);
    check("R4", 16'hA000, 1, 0);
    // R10 truncation
    set_all(255, 2047, 65535, 0);
    check("R10", 16'h7ABC, 1, 0);
    check("R10", 16'h8ABC, 1, 0);
    // R7 low byte alone does not change the windows
    wr_reg(1, 8'h55);
    check("R7", 16'h8000, 1, 0);
    wr_reg(2, 0); m_frame = 16'h0055;
    check("R7", 16'h8000, 1, 0);
    // R8 deferred load while busy
    wr_reg(1, 8'h20);
    acc_busy = 1'b1;
    wr_reg(2, 8'h01);
    check("R8", 16'h8000, 1, 0);
    @(posedge clk); @(negedge clk);
    check("R8", 16'h8000, 1, 0);
    acc_busy = 1'b0;
    @(posedge clk); @(negedge clk);
    m_frame = 16'h0120;
    check("R8", 16'h8000, 1, 0);
    // random mix
    for (int i = 0; i < 300; i++) begin
      set_all($urandom_range(0, 255), $urandom_range(0, 3000),
              $urandom_range(0, 3000), $urandom_range(0, 3000));
      for (int j = 0; j < 8; j++)
        check("R4", int'($urandom_range(0, 65535)), 1'($urandom), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule